// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block watches the single request stream into a shared memory. It keeps the address reservations that let load-reserved and store-conditional pairs from several requesting contexts work correctly. A context is the pair of a CPU number and a thread number. A read that carries the locked flag places a reservation for its context on the aligned granule that holds its address. A context owns at most one reservation at a time.

Every write searches the whole table and wipes out each reservation on the written granule, whoever owns it. A plain write is always allowed. A conditional write is allowed only if its own context still holds a reservation on that granule, and it reports pass or fail on a status bit.

The decision is combinational and is made in the same cycle as the request. Table changes take effect on the following clock edge. When the table is full and a new context reserves, the reservation that was created earliest is replaced. The memory array and the data path lie outside this block. It drives only a write enable and the conditional status.

Top module: `resv_monitor`

## Requirements
- R1: After reset the table holds no reservation, so a conditional write from any context gives wr_en=0 and sc_pass=0.
- R2: A read with req_locked=1 reserves the granule for its context. A later conditional write (req_write=1, req_locked=1) from the same context to that granule gives wr_en=1 and sc_pass=1 in the same cycle, and consumes the reservation.
- R3: Addresses are compared per granule of GRAN_BYTES (default 16) bytes. Addresses that differ only in the low log2(GRAN_BYTES) bits match, and addresses that differ above those bits do not.
- R4: A context holds one reservation. A second locked read from it moves the reservation, so a conditional write to the old granule fails.
- R5: Any write, plain or conditional, removes the reservations of all contexts on the written granule.
- R6: A plain write (req_write=1, req_locked=0) always gives wr_en=1 and sc_pass=0, whatever the table holds.
- R7: A conditional write to a granule that only another context has reserved fails (wr_en=0, sc_pass=0), and it still removes that other context's reservation.
- R8: A conditional write to a granule other than the one its context reserved fails and leaves that reservation in place.
- R9: With all ENTRIES (default 8) entries in use, a locked read from a context that has no entry replaces the entry created earliest. Moving an existing reservation to a new address does not change its age.
- R10: Plain reads and idle cycles (req_valid=0) change no reservation and give wr_en=0 and sc_pass=0. A locked read also gives wr_en=0 and sc_pass=0.
- R11: The outputs reflect the table as left by all earlier requests, for any back-to-back mix of requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all reservations |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_locked | input | 1 | Locked read (reserve) or conditional write |
| req_addr | input | ADDR_W | Byte address of the request |
| req_cpu | input | CPU_W | CPU number of the requesting context |
| req_thr | input | THR_W | Thread number of the requesting context |
| wr_en | output | 1 | The memory write may proceed this cycle |
| sc_pass | output | 1 | Conditional write succeeded (1) this cycle |

## Verification
The hardest case to reach from the ports is replacement of the oldest entry after the table has had holes punched in it and some reservations have been moved. Only then do creation order, slot position and most recent use all disagree. The directed stimulus fills every entry, moves the first one, frees a middle one with a plain write, refills the hole and then overflows. Conditional writes then show which context lost its entry. Random traffic spreads twelve contexts over eight entries and six granules, so evictions, cross-context removals and consumed reservations come up again and again against the bench's reference table.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [2:0] {
    OP_IDLE       = 3'd0,
    OP_READ       = 3'd1,
    OP_LOAD_RSV   = 3'd2,
    OP_STORE      = 3'd3,
    OP_STORE_COND = 3'd4
  } op_e;

  function automatic op_e classify(input logic vld, input logic wr, input logic lk);
    if (!vld) return OP_IDLE;
    if (wr)   return lk ? OP_STORE_COND : OP_STORE;
    return lk ? OP_LOAD_RSV : OP_READ;
  endfunction

endpackage

// File: rtl/resv_match.sv
module resv_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 32,
  parameter int CTX_W   = 4
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag,
  input  logic [ENTRIES-1:0][CTX_W-1:0]  ent_ctx,
  input  logic [TAG_W-1:0]               req_tag,
  input  logic [CTX_W-1:0]               req_ctx,
  output logic [ENTRIES-1:0]             tag_hit,
  output logic [ENTRIES-1:0]             ctx_hit,
  output logic                           own_hit
);

  // One comparator pair per entry, all searched in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign tag_hit[g] = ent_valid[g] && (ent_tag[g] == req_tag);
    assign ctx_hit[g] = ent_valid[g] && (ent_ctx[g] == req_ctx);
  end

  assign own_hit = |(tag_hit & ctx_hit);

endmodule

// File: rtl/resv_age.sv
module resv_age #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_en,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic [ENTRIES-1:0] ent_valid,
  output logic [IDX_W-1:0]   victim_idx
);

  // older_q[i][j] set: entry i was created before entry j
  logic [ENTRIES-1:0][ENTRIES-1:0] older_q;
  logic [ENTRIES-1:0]              victim_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      older_q <= '0;
    end else if (alloc_en) begin
      for (int j = 0; j < ENTRIES; j++) begin
        older_q[alloc_idx][j] <= 1'b0;
        if (IDX_W'(j) != alloc_idx) older_q[j][alloc_idx] <= 1'b1;
      end
    end
  end

  // An entry is the victim when it is older than every other live entry
  always_comb begin
    victim_vec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      logic is_old;
      is_old = ent_valid[i];
      for (int j = 0; j < ENTRIES; j++) begin
        if (j != i && ent_valid[j] && !older_q[i][j]) is_old = 1'b0;
      end
      victim_vec[i] = is_old;
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (victim_vec[i]) victim_idx = IDX_W'(i);
    end
  end

  // R9
  single_victim_chk: assert property (@(posedge clk) disable iff (rst)
    (&ent_valid) |-> ($countones(victim_vec) == 1));

endmodule

// File: rtl/resv_table.sv
module resv_table
  import resv_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 32,
  parameter int CTX_W   = 4,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  op_e                            op,
  input  logic [TAG_W-1:0]               req_tag,
  input  logic [CTX_W-1:0]               req_ctx,
  input  logic [ENTRIES-1:0]             tag_hit,
  input  logic [ENTRIES-1:0]             ctx_hit,
  input  logic [IDX_W-1:0]               victim_idx,
  output logic [ENTRIES-1:0]             ent_valid,
  output logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag,
  output logic [ENTRIES-1:0][CTX_W-1:0]  ent_ctx,
  output logic                           alloc_en,
  output logic [IDX_W-1:0]               alloc_idx
);

  logic             is_lr, is_st;
  logic             own_any, free_any;
  logic [IDX_W-1:0] own_idx, free_idx, wr_idx;

  assign is_lr = (op == OP_LOAD_RSV);
  assign is_st = (op == OP_STORE) || (op == OP_STORE_COND);

  always_comb begin
    own_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ctx_hit[i]) own_idx = IDX_W'(i);
    end
  end

  // lowest free slot wins
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign own_any   = |ctx_hit;
  assign free_any  = ~&ent_valid;
  assign alloc_en  = is_lr && !own_any;
  assign alloc_idx = free_any ? free_idx : victim_idx;
  assign wr_idx    = own_any ? own_idx : alloc_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
    end else if (is_st) begin
      ent_valid <= ent_valid & ~tag_hit;
    end else if (is_lr) begin
      ent_valid[wr_idx] <= 1'b1;
    end
  end

  // payload fields carry no reset; the valid bits qualify them
  always_ff @(posedge clk) begin
    if (is_lr) begin
      ent_tag[wr_idx] <= req_tag;
      ent_ctx[wr_idx] <= req_ctx;
    end
  end

  // ---------------- checks ----------------
  function automatic logic tag_live(input logic [TAG_W-1:0] t);
    logic r;
    r = 1'b0;
    for (int i = 0; i < ENTRIES; i++) r = r | (ent_valid[i] && ent_tag[i] == t);
    return r;
  endfunction

  function automatic logic pair_live(input logic [TAG_W-1:0] t, input logic [CTX_W-1:0] c);
    logic r;
    r = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      r = r | (ent_valid[i] && ent_tag[i] == t && ent_ctx[i] == c);
    return r;
  endfunction

  logic dup_ctx;
  always_comb begin
    dup_ctx = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (ent_valid[i] && ent_valid[j] && ent_ctx[i] == ent_ctx[j]) dup_ctx = 1'b1;
  end

  // R5
  purge_on_store_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(is_st)) |-> !tag_live($past(req_tag)));

  // R2
  reserve_recorded_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(is_lr)) |-> pair_live($past(req_tag), $past(req_ctx)));

  // R4
  one_per_ctx_chk: assert property (@(posedge clk) disable iff (rst) !dup_ctx);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CPU_W      = 2,
  parameter int THR_W      = 2,
  parameter int ENTRIES    = 8,
  parameter int GRAN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_locked,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [THR_W-1:0]  req_thr,
  output logic              wr_en,
  output logic              sc_pass
);

  localparam int CTX_W = CPU_W + THR_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ADDR_W-1:0] GRAN_MASK = ~ADDR_W'(GRAN_BYTES - 1);

  op_e                           cur_op;
  logic [ADDR_W-1:0]             gran_addr;
  logic [CTX_W-1:0]              ctx;
  logic [ENTRIES-1:0]            ent_valid, tag_hit, ctx_hit;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag;
  logic [ENTRIES-1:0][CTX_W-1:0] ent_ctx;
  logic                          own_hit, alloc_en;
  logic [IDX_W-1:0]              alloc_idx, victim_idx;

  assign cur_op    = classify(req_valid, req_write, req_locked);
  assign gran_addr = req_addr & GRAN_MASK;
  assign ctx       = {req_cpu, req_thr};

  resv_match #(.ENTRIES(ENTRIES), .TAG_W(ADDR_W), .CTX_W(CTX_W)) u_match (
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .ent_ctx   (ent_ctx),
    .req_tag   (gran_addr),
    .req_ctx   (ctx),
    .tag_hit   (tag_hit),
    .ctx_hit   (ctx_hit),
    .own_hit   (own_hit)
  );

  resv_table #(.ENTRIES(ENTRIES), .TAG_W(ADDR_W), .CTX_W(CTX_W), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .op         (cur_op),
    .req_tag    (gran_addr),
    .req_ctx    (ctx),
    .tag_hit    (tag_hit),
    .ctx_hit    (ctx_hit),
    .victim_idx (victim_idx),
    .ent_valid  (ent_valid),
    .ent_tag    (ent_tag),
    .ent_ctx    (ent_ctx),
    .alloc_en   (alloc_en),
    .alloc_idx  (alloc_idx)
  );

  resv_age #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_age (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (alloc_en),
    .alloc_idx  (alloc_idx),
    .ent_valid  (ent_valid),
    .victim_idx (victim_idx)
  );

  assign sc_pass = (cur_op == OP_STORE_COND) && own_hit;
  assign wr_en   = (cur_op == OP_STORE) || sc_pass;

  // R2
  cond_status_chk: assert property (@(posedge clk) disable iff (rst)
    sc_pass |-> (req_valid && req_write && req_locked));

  // R6
  plain_store_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_locked) |-> (wr_en && !sc_pass));

  // R10
  no_write_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || !req_write) |-> (!wr_en && !sc_pass));

endmodule

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;

  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_locked = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_cpu = '0, req_thr = '0;
  logic        wr_en, sc_pass;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference table
  bit m_valid [NE];
  int m_ctx   [NE];
  int m_tag   [NE];
  int m_stamp [NE];
  int stamp = 0;

  always #2 clk = ~clk;

  resv_monitor u_resv_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_locked(req_locked), .req_addr(req_addr), .req_cpu(req_cpu),
    .req_thr(req_thr), .wr_en(wr_en), .sc_pass(sc_pass)
  );

  function automatic bit own_live(int c, int t);
    for (int i = 0; i < NE; i++)
      if (m_valid[i] && m_ctx[i] == c && m_tag[i] == t) return 1;
    return 0;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NE; i++) m_valid[i] = 0;
  endtask

  task automatic model_update(bit w, bit l, int c, int t);
    int slot;
    if (w) begin
      for (int i = 0; i < NE; i++) if (m_valid[i] && m_tag[i] == t) m_valid[i] = 0;
    end else if (l) begin
      slot = -1;
      for (int i = 0; i < NE; i++) if (m_valid[i] && m_ctx[i] == c) slot = i;
      if (slot >= 0) begin
        m_tag[slot] = t;
      end else begin
        for (int i = NE - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
        if (slot < 0) begin
          slot = 0;
          for (int i = 1; i < NE; i++) if (m_stamp[i] < m_stamp[slot]) slot = i;
        end
        m_valid[slot] = 1; m_ctx[slot] = c; m_tag[slot] = t; m_stamp[slot] = stamp;
        stamp++;
      end
    end
  endtask

  task automatic check2(string rq, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {wr_en,sc_pass} actual %b expected %b", rq, act, exp);
    end
  endtask

  task automatic issue(bit w, bit l, logic [31:0] a, int c, string rq);
    bit ew, es;
    int t;
    t = int'(a[31:4]);
    @(negedge clk);
    req_valid = 1; req_write = w; req_locked = l; req_addr = a;
    {req_cpu, req_thr} = 4'(c);
    #1;
    es = w && l && own_live(c, t);
    ew = w && (!l || es);
    check2(rq, {wr_en, sc_pass}, {ew, es});
    @(posedge clk);
    model_update(w, l, c, t);
    #1 req_valid = 0;
  endtask

  task automatic idle_check(string rq);
    @(negedge clk);
    req_valid = 0; req_write = 1; req_locked = 1;
    #1 check2(rq, {wr_en, sc_pass}, 2'b00);
    @(posedge clk);
    #1 req_write = 0; req_locked = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_clear();
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_ret;
    model_clear();
    do_reset();

    // R1: empty table after reset
    issue(1, 1, 32'h100, 0, "R1");
    issue(1, 1, 32'h200, 5, "R1");
    idle_check("R10");

    // R2 and R3: reserve, then pass within the same granule, then consumed
    issue(0, 1, 32'h200, 1, "R2");
    issue(1, 1, 32'h204, 1, "R2");
    issue(1, 1, 32'h200, 1, "R2");

    // R3 and R8: next granule does not match; own reservation survives
    issue(0, 1, 32'h30F, 2, "R3");
    issue(1, 1, 32'h310, 2, "R3");
    issue(1, 1, 32'h300, 2, "R8");

    // R4: reservation moves
    issue(0, 1, 32'h400, 3, "R4");
    issue(0, 1, 32'h500, 3, "R4");
    issue(1, 1, 32'h400, 3, "R4");
    issue(1, 1, 32'h500, 3, "R4");

    // R5 and R6: plain write clears all contexts on the granule
    issue(0, 1, 32'h600, 4, "R5");
    issue(0, 1, 32'h608, 5, "R5");
    issue(1, 0, 32'h60C, 6, "R6");
    issue(1, 1, 32'h600, 4, "R5");
    issue(1, 1, 32'h600, 5, "R5");

    // R7: foreign conditional write fails and consumes
    issue(0, 1, 32'h700, 7, "R7");
    issue(1, 1, 32'h700, 8, "R7");
    issue(1, 1, 32'h700, 7, "R7");

    // R10: plain read and idle leave the reservation
    issue(0, 1, 32'h800, 9, "R10");
    issue(0, 0, 32'h800, 10, "R10");
    idle_check("R10");
    issue(1, 1, 32'h800, 9, "R10");

    // R6: plain write with nothing reserved
    issue(1, 0, 32'h900, 11, "R6");

    // R9: oldest-created replacement with a hole and a moved entry
    do_reset();
    for (int c = 0; c < 8; c++) issue(0, 1, 32'h1000 + 32'(c * 16), c, "R9");
    issue(0, 1, 32'h1080, 0, "R9");
    issue(1, 0, 32'h1030, 12, "R9");
    issue(0, 1, 32'h1090, 8, "R9");
    issue(0, 1, 32'h10A0, 9, "R9");
    issue(1, 1, 32'h1080, 0, "R9");
    issue(1, 1, 32'h1010, 1, "R9");
    issue(1, 1, 32'h1090, 8, "R9");
    issue(1, 1, 32'h10A0, 9, "R9");
    issue(1, 1, 32'h1030, 3, "R9");

    // R11: random back-to-back traffic
    do_reset();
    seed_ret = int'($urandom(32'h5EED));
    for (int n = 0; n < 4000; n++) begin
      int sel, c;
      logic [31:0] a;
      sel = int'($urandom % 100);
      c   = int'($urandom % 12);
      a   = 32'h2000 + 32'(($urandom % 6) * 16) + 32'($urandom % 16);
      if (sel < 40)      issue(0, 1, a, c, "R11");
      else if (sel < 50) issue(0, 0, a, c, "R11");
      else if (sel < 70) issue(1, 0, a, c, "R11");
      else               issue(1, 1, a, c, "R11");
    end

    // R1: reset clears a busy table
    issue(0, 1, 32'h3000, 2, "R1");
    do_reset();
    issue(1, 1, 32'h3000, 2, "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule